// File: doc/BRIEF.md
# Two-channel DRAM command slot multiplexer

This block lets two independent memory channels share one DRAM command/address bus. The controller runs on a slow clock. Each slow cycle is split into four fast time slots, which a downstream serializer shifts out. Each channel owns a fixed pair of slots. Channel 0 owns slots 0 and 1, and channel 1 owns slots 2 and 3. A per-channel slot bit picks which slot of its pair carries the command. Because the pairs are fixed, both channels can issue a command in the same slow cycle without arbitration.

Every slow cycle each channel presents one command as active-low row strobe, column strobe and write enable, together with a bank and a row/column address. The block registers everything on the slow clock. It then emits four-slot parallel words: one bit per slot for each control line, plus one address value and one bank value per slot. Slot 0 is the first slot on the bus. A tristate input flags every slot of the word as high impedance without moving any slot.

A typical use keeps channel 0 in bank 0 and channel 1 in bank 1, so both can hold rows open at once. Each channel runs its own activate, read/write, precharge order. The block passes that order through unchanged.

Top module: `cmd_slot_mux`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next output word is idle. All bits of ras_slots_n, cas_slots_n and we_slots_n are 1, and addr_slots, bank_slots and tri_slots are all 0.
- R2: Inputs sampled at one rising edge of clk appear on the outputs right after that edge, and they stay there until the next edge. A command is never held into a second cycle.
- R3: Channel 0 uses slot_sel[1]. When slot_sel[1] is 0, its write enable (ch0_cmd_n bit 0) is placed in slot 0 and slot 1 is driven 1. When slot_sel[1] is 1, it is placed in slot 1 and slot 0 is driven 1.
- R4: Channel 1 uses slot_sel[0]. When slot_sel[0] is 0, its write enable (ch1_cmd_n bit 0) is placed in slot 2 and slot 3 is driven 1. When slot_sel[0] is 1, it is placed in slot 3 and slot 2 is driven 1.
- R5: The command field uses bit 0 for write enable, bit 1 for column strobe and bit 2 for row strobe, all active low. The column and row strobes follow the same slot placement as write enable, on cas_slots_n and ras_slots_n. A command of 3'b111 (no operation) leaves all of that channel's slots at 1.
- R6: A command from one channel never drives a low level into a slot owned by the other channel, for all four values of slot_sel.
- R7: Slot i of addr_slots is bits [i*ADDR_W +: ADDR_W], and slot i of bank_slots is bits [i*BANK_W +: BANK_W]. Slots 0 and 1 carry channel 0's address and bank. Slots 2 and 3 carry channel 1's address and bank.
- R8: When tri_en is 1 at a sampling edge, the next tri_slots value is 4'b1111; when tri_en is 0, it is 4'b0000. Control, address and bank slots are the same in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch0_cmd_n | input | 3 | Channel 0 command {ras_n, cas_n, we_n} |
| ch0_addr | input | ADDR_W | Channel 0 row/column address |
| ch0_bank | input | BANK_W | Channel 0 bank |
| ch1_cmd_n | input | 3 | Channel 1 command {ras_n, cas_n, we_n} |
| ch1_addr | input | ADDR_W | Channel 1 row/column address |
| ch1_bank | input | BANK_W | Channel 1 bank |
| slot_sel | input | 2 | Bit 1: channel 0 slot choice; bit 0: channel 1 slot choice |
| tri_en | input | 1 | Flags all slots of the word as high impedance |
| ras_slots_n | output | 4 | Row strobe per slot, bit i = slot i |
| cas_slots_n | output | 4 | Column strobe per slot |
| we_slots_n | output | 4 | Write enable per slot |
| addr_slots | output | 4*ADDR_W | Address per slot |
| bank_slots | output | 4*BANK_W | Bank per slot |
| tri_slots | output | 4 | High-impedance flag per slot |

## Verification
The bench builds the block with its defaults, ADDR_W=15 and BANK_W=3. With these widths, all-ones and alternating address patterns fill the full row width, so a misrouted or truncated slot field shows up as a wrong bit. Random banks cover all eight bank values, which exercises every bit of each bank slot. The stimulus also runs interleaved activate, read and precharge sequences, with channel 0 in bank 0 and channel 1 in bank 1, under every slot_sel combination.

// File: rtl/cmd_slot_pkg.sv
// Shared constants and types for the two-channel command slot multiplexer.
// Assumes exactly two channels, each owning two consecutive slots.
package cmd_slot_pkg;
    localparam int NUM_CH       = 2;
    localparam int SLOTS_PER_CH = 2;
    localparam int NUM_SLOTS    = NUM_CH * SLOTS_PER_CH;
    localparam int CMD_W        = 3;
    localparam int WE_BIT       = 0;
    localparam int CAS_BIT      = 1;
    localparam int RAS_BIT      = 2;

    // One slow cycle's worth of control bits, bit i = slot i.
    typedef struct packed {
        logic [NUM_SLOTS-1:0] ras_n;
        logic [NUM_SLOTS-1:0] cas_n;
        logic [NUM_SLOTS-1:0] we_n;
    } ctl_word_t;
endpackage

// File: rtl/chan_slot_place.sv
// Places one channel's command into its two-slot pair.
// The selected slot carries the active-low control levels.
// The other slot is held high, which is idle.
// The address and bank are repeated across both slots of the pair.
// Purely combinational; assumes sel is a single bit.
module chan_slot_place
    import cmd_slot_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 3
) (
    input  logic [CMD_W-1:0]               cmd_n,
    input  logic                           sel,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [BANK_W-1:0]              bank,
    output logic [SLOTS_PER_CH-1:0]        ras_pair_n,
    output logic [SLOTS_PER_CH-1:0]        cas_pair_n,
    output logic [SLOTS_PER_CH-1:0]        we_pair_n,
    output logic [SLOTS_PER_CH*ADDR_W-1:0] addr_pair,
    output logic [SLOTS_PER_CH*BANK_W-1:0] bank_pair
);
    genvar s;
    generate
        for (s = 0; s < SLOTS_PER_CH; s++) begin : g_slot
            // Steer each control level into the chosen slot; park the other high.
            always_comb begin
                if (sel == s[0]) begin
                    ras_pair_n[s] = cmd_n[RAS_BIT];
                    cas_pair_n[s] = cmd_n[CAS_BIT];
                    we_pair_n[s]  = cmd_n[WE_BIT];
                end else begin
                    ras_pair_n[s] = 1'b1;
                    cas_pair_n[s] = 1'b1;
                    we_pair_n[s]  = 1'b1;
                end
            end
            // Hold address and bank for both slots of the pair.
            assign addr_pair[s*ADDR_W +: ADDR_W] = addr;
            assign bank_pair[s*BANK_W +: BANK_W] = bank;
        end
    endgenerate
endmodule

// File: rtl/slot_word_reg.sv
// Generic slow-clock register for one output field with a reset value.
// Assumes a synchronous active-low reset.
module slot_word_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the next word, or load the idle value during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/cmd_slot_mux.sv
// Merges two channels' DRAM commands onto a shared four-slot command bus.
// Channel c owns slots 2c and 2c+1, and its slot bit picks one of them.
// Channel 0 reads slot_sel[1]; channel 1 reads slot_sel[0].
// Outputs are registered once on the slow clock.
// Assumes the downstream serializer sends slot 0 first.
module cmd_slot_mux
    import cmd_slot_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CMD_W-1:0]            ch0_cmd_n,
    input  logic [ADDR_W-1:0]           ch0_addr,
    input  logic [BANK_W-1:0]           ch0_bank,
    input  logic [CMD_W-1:0]            ch1_cmd_n,
    input  logic [ADDR_W-1:0]           ch1_addr,
    input  logic [BANK_W-1:0]           ch1_bank,
    input  logic [NUM_CH-1:0]           slot_sel,
    input  logic                        tri_en,
    output logic [NUM_SLOTS-1:0]        ras_slots_n,
    output logic [NUM_SLOTS-1:0]        cas_slots_n,
    output logic [NUM_SLOTS-1:0]        we_slots_n,
    output logic [NUM_SLOTS*ADDR_W-1:0] addr_slots,
    output logic [NUM_SLOTS*BANK_W-1:0] bank_slots,
    output logic [NUM_SLOTS-1:0]        tri_slots
);
    localparam int CTL_W  = $bits(ctl_word_t);
    localparam int PAIR_A = SLOTS_PER_CH * ADDR_W;
    localparam int PAIR_B = SLOTS_PER_CH * BANK_W;

    logic [CMD_W-1:0]  cmd_n_arr [NUM_CH];
    logic [ADDR_W-1:0] addr_arr  [NUM_CH];
    logic [BANK_W-1:0] bank_arr  [NUM_CH];

    ctl_word_t                   ctl_nxt;
    ctl_word_t                   ctl_q;
    logic [NUM_SLOTS*ADDR_W-1:0] addr_nxt;
    logic [NUM_SLOTS*BANK_W-1:0] bank_nxt;
    logic [NUM_SLOTS-1:0]        tri_nxt;

    // Gather the channel ports into arrays indexed by channel.
    assign cmd_n_arr[0] = ch0_cmd_n;
    assign cmd_n_arr[1] = ch1_cmd_n;
    assign addr_arr[0]  = ch0_addr;
    assign addr_arr[1]  = ch1_addr;
    assign bank_arr[0]  = ch0_bank;
    assign bank_arr[1]  = ch1_bank;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            chan_slot_place #(
                .ADDR_W (ADDR_W),
                .BANK_W (BANK_W)
            ) place_i (
                .cmd_n      (cmd_n_arr[c]),
                .sel        (slot_sel[NUM_CH-1-c]),
                .addr       (addr_arr[c]),
                .bank       (bank_arr[c]),
                .ras_pair_n (ctl_nxt.ras_n[c*SLOTS_PER_CH +: SLOTS_PER_CH]),
                .cas_pair_n (ctl_nxt.cas_n[c*SLOTS_PER_CH +: SLOTS_PER_CH]),
                .we_pair_n  (ctl_nxt.we_n[c*SLOTS_PER_CH +: SLOTS_PER_CH]),
                .addr_pair  (addr_nxt[c*PAIR_A +: PAIR_A]),
                .bank_pair  (bank_nxt[c*PAIR_B +: PAIR_B])
            );
        end
    endgenerate

    // The tristate flag covers every slot alike.
    assign tri_nxt = {NUM_SLOTS{tri_en}};

    slot_word_reg #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) ctl_reg_i (
        .clk (clk), .rst_n (rst_n), .d (ctl_nxt), .q (ctl_q)
    );
    slot_word_reg #(.W(NUM_SLOTS*ADDR_W)) addr_reg_i (
        .clk (clk), .rst_n (rst_n), .d (addr_nxt), .q (addr_slots)
    );
    slot_word_reg #(.W(NUM_SLOTS*BANK_W)) bank_reg_i (
        .clk (clk), .rst_n (rst_n), .d (bank_nxt), .q (bank_slots)
    );
    slot_word_reg #(.W(NUM_SLOTS)) tri_reg_i (
        .clk (clk), .rst_n (rst_n), .d (tri_nxt), .q (tri_slots)
    );

    // Unpack the registered control word onto the output pins.
    assign ras_slots_n = ctl_q.ras_n;
    assign cas_slots_n = ctl_q.cas_n;
    assign we_slots_n  = ctl_q.we_n;
endmodule

// File: rtl/cmd_slot_mux_chk.sv
// Property checker for cmd_slot_mux, attached by bind.
// Observes ports only.
module cmd_slot_mux_chk #(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          ch0_cmd_n,
    input logic [ADDR_W-1:0]   ch0_addr,
    input logic [BANK_W-1:0]   ch0_bank,
    input logic [2:0]          ch1_cmd_n,
    input logic [ADDR_W-1:0]   ch1_addr,
    input logic [BANK_W-1:0]   ch1_bank,
    input logic [1:0]          slot_sel,
    input logic                tri_en,
    input logic [3:0]          ras_slots_n,
    input logic [3:0]          cas_slots_n,
    input logic [3:0]          we_slots_n,
    input logic [4*ADDR_W-1:0] addr_slots,
    input logic [4*BANK_W-1:0] bank_slots,
    input logic [3:0]          tri_slots
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (ras_slots_n == 4'hF && cas_slots_n == 4'hF && we_slots_n == 4'hF
                    && addr_slots == '0 && bank_slots == '0 && tri_slots == 4'h0));

    p_ch0_low_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch0_cmd_n[0] && !slot_sel[1]) |=> (we_slots_n[1:0] == 2'b10));
    p_ch0_high_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch0_cmd_n[0] && slot_sel[1]) |=> (we_slots_n[1:0] == 2'b01));

    p_ch1_low_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch1_cmd_n[0] && !slot_sel[0]) |=> (we_slots_n[3:2] == 2'b10));
    p_ch1_high_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch1_cmd_n[0] && slot_sel[0]) |=> (we_slots_n[3:2] == 2'b01));

    p_nop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_cmd_n == 3'b111) |=> (ras_slots_n[1:0] == 2'b11 && cas_slots_n[1:0] == 2'b11
                                   && we_slots_n[1:0] == 2'b11));

    p_pair_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ras_slots_n[1:0]) >= 1 && $countones(ras_slots_n[3:2]) >= 1
         && $countones(cas_slots_n[1:0]) >= 1 && $countones(cas_slots_n[3:2]) >= 1));

    p_addr_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (addr_slots[ADDR_W-1:0] == $past(ch0_addr)
                  && addr_slots[3*ADDR_W +: ADDR_W] == $past(ch1_addr)
                  && bank_slots[2*BANK_W +: BANK_W] == $past(ch1_bank)));

    p_tri_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tri_en |=> (tri_slots == 4'hF));
    p_tri_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tri_en |=> (tri_slots == 4'h0));
endmodule

bind cmd_slot_mux cmd_slot_mux_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) chk_i (.*);

// File: tb/cmd_slot_mux_tb_top.sv
// Self-checking bench for cmd_slot_mux.
// A behavioural model predicts every output word from the inputs sampled at
// each rising edge. Directed phases cover latency, channel isolation and tristate.
module cmd_slot_mux_tb_top;
    localparam int AW = 15;
    localparam int BW = 3;
    localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010;

    logic clk = 1'b0;
    logic rst_n;
    logic [2:0] ch0_cmd_n, ch1_cmd_n;
    logic [AW-1:0] ch0_addr, ch1_addr;
    logic [BW-1:0] ch0_bank, ch1_bank;
    logic [1:0] slot_sel;
    logic tri_en;
    logic [3:0] ras_slots_n, cas_slots_n, we_slots_n, tri_slots;
    logic [4*AW-1:0] addr_slots;
    logic [4*BW-1:0] bank_slots;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmd_slot_mux #(.ADDR_W(AW), .BANK_W(BW)) dut_i (.*);

    // Expected outputs predicted at each rising edge.
    logic [3:0] e_ras, e_cas, e_we, e_tri;
    logic [4*AW-1:0] e_addr;
    logic [4*BW-1:0] e_bank;
    bit e_rst;
    bit e_valid = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference model: one slow cycle of latency, slot = 2*channel + slot bit.
    always @(posedge clk) begin
        int b0, b1;
        e_valid <= 1;
        e_rst   <= !rst_n;
        if (!rst_n) begin
            e_ras <= 4'hF; e_cas <= 4'hF; e_we <= 4'hF;
            e_addr <= '0; e_bank <= '0; e_tri <= 4'h0;
        end else begin
            logic [3:0] r, c, w;
            r = 4'hF; c = 4'hF; w = 4'hF;
            b0 = slot_sel[1] ? 1 : 0;
            b1 = slot_sel[0] ? 3 : 2;
            r[b0] = ch0_cmd_n[2]; c[b0] = ch0_cmd_n[1]; w[b0] = ch0_cmd_n[0];
            r[b1] = ch1_cmd_n[2]; c[b1] = ch1_cmd_n[1]; w[b1] = ch1_cmd_n[0];
            e_ras <= r; e_cas <= c; e_we <= w;
            e_addr <= {ch1_addr, ch1_addr, ch0_addr, ch0_addr};
            e_bank <= {ch1_bank, ch1_bank, ch0_bank, ch0_bank};
            e_tri <= tri_en ? 4'hF : 4'h0;
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (e_valid && !done) begin
            if (e_rst) begin
                chk("R1", "ras", 64'(ras_slots_n), 64'(e_ras));
                chk("R1", "we", 64'(we_slots_n), 64'(e_we));
                chk("R1", "addr", 64'(addr_slots), 64'(e_addr));
                chk("R1", "tri", 64'(tri_slots), 64'(e_tri));
            end else begin
                chk("R3", "we ch0 pair", 64'(we_slots_n[1:0]), 64'(e_we[1:0]));
                chk("R4", "we ch1 pair", 64'(we_slots_n[3:2]), 64'(e_we[3:2]));
                chk("R5", "cas", 64'(cas_slots_n), 64'(e_cas));
                chk("R5", "ras", 64'(ras_slots_n), 64'(e_ras));
                chk("R7", "addr", 64'(addr_slots), 64'(e_addr));
                chk("R7", "bank", 64'(bank_slots), 64'(e_bank));
                chk("R8", "tri", 64'(tri_slots), 64'(e_tri));
            end
        end
    end

    task automatic drive(input logic [2:0] c0, input logic [2:0] c1, input logic [1:0] sel);
        ch0_cmd_n = c0; ch1_cmd_n = c1; slot_sel = sel;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1;
            finish_run();
        end
    end

    initial begin
        rst_n = 0; tri_en = 0;
        ch0_addr = '0; ch1_addr = '0; ch0_bank = 3'd0; ch1_bank = 3'd1;
        drive(NOP, NOP, 2'b00);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: a command appears right after its edge and is gone one cycle later.
        drive(ACT, NOP, 2'b00); ch0_addr = 15'h7FFF;
        @(negedge clk);
        chk("R2", "ras after one edge", 64'(ras_slots_n), 64'(4'b1110));
        drive(NOP, NOP, 2'b00);
        @(negedge clk);
        chk("R2", "ras released", 64'(ras_slots_n), 64'(4'b1111));

        // R6: one channel active, the other's slots stay high, all slot_sel values.
        for (int s = 0; s < 4; s++) begin
            drive(WR, NOP, 2'(s));
            @(negedge clk);
            chk("R6", "ch1 slots idle", 64'({ras_slots_n[3:2], cas_slots_n[3:2], we_slots_n[3:2]}), 64'(6'h3F));
            chk("R6", "ch0 one cas slot", 64'($countones(cas_slots_n[1:0])), 64'(1));
            drive(NOP, WR, 2'(s));
            @(negedge clk);
            chk("R6", "ch0 slots idle", 64'({ras_slots_n[1:0], cas_slots_n[1:0], we_slots_n[1:0]}), 64'(6'h3F));
            chk("R6", "ch1 one cas slot", 64'($countones(cas_slots_n[3:2])), 64'(1));
        end

        // Interleaved activate/read/precharge, channel 1 in bank 1.
        ch0_bank = 3'd0; ch1_bank = 3'd1;
        for (int s = 0; s < 4; s++) begin
            ch0_addr = 15'h5555; ch1_addr = 15'h2AAA;
            drive(ACT, ACT, 2'(s)); @(negedge clk);
            drive(RD, WR, 2'(s));  @(negedge clk);
            drive(PRE, PRE, 2'(s)); @(negedge clk);
        end

        // R8: tristate flags every slot while commands keep their placement.
        tri_en = 1; drive(RD, ACT, 2'b10);
        @(negedge clk);
        chk("R8", "tri all slots", 64'(tri_slots), 64'(4'hF));
        chk("R8", "ras kept", 64'(ras_slots_n), 64'(4'b1011));
        tri_en = 0;

        // Random traffic compared by the model.
        for (int i = 0; i < 400; i++) begin
            ch0_cmd_n = 3'($urandom); ch1_cmd_n = 3'($urandom);
            slot_sel = 2'($urandom);
            ch0_addr = AW'($urandom); ch1_addr = AW'($urandom);
            ch0_bank = BW'($urandom); ch1_bank = BW'($urandom);
            tri_en = ($urandom % 5) == 0;
            @(negedge clk);
        end

        // R1: reset in mid-traffic returns the word to idle.
        drive(ACT, WR, 2'b11); tri_en = 1; rst_n = 0;
        @(negedge clk);
        chk("R1", "cas idle", 64'(cas_slots_n), 64'(4'hF));
        chk("R1", "bank zero", 64'(bank_slots), 64'(0));
        rst_n = 1; tri_en = 0; drive(NOP, NOP, 2'b00);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule